// File: doc/BRIEF.md
# DRAM Command Sequencer

This block sits between a single-request client and a synchronous DRAM channel of one or more ranks. It takes a request made of a flat address, a write flag and one burst of write data. It then produces the command stream the memory needs: chip selects, a bank precharge, a row activate, a column read or write, and the data beats of a burst. The spacing between these commands comes from compile-time timing parameters. Only one request is in flight at a time. The client holds its request until the block accepts it.

The block remembers which row is open in every bank of every rank. When a request falls in the open row, the block goes straight to the column command. When it falls in a closed bank, the block activates the row first. When a different row is open in that bank, the block precharges, activates, and only then issues the column command. The block advances the column addresses of a burst by itself. A free-running interval timer forces a refresh between requests. The refresh precharges every bank, refreshes, and leaves all rows closed.

Top module: `dram_cmd_seq`

## Requirements
- R1: `req_addr` is split, from most significant bit down, into rank (RANK_W), bank (BANK_W), row (ROW_W) and column (COL_W). Every request command carries the bank on `dram_bank` and asserts the single bit `dram_cs[rank]`. The row travels on `dram_addr` with an activate, and the column with a column command; both are zero-extended.
- R2: Outside refresh commands, at most one bit of `dram_cs` is high in any cycle, including the data beats. The bench also checks the exact value of `dram_cs` in every cycle. Only the refresh precharge and the refresh command assert every chip select.
- R3: If a request targets a bank whose open row differs from the requested row, `dram_pre` is pulsed for that bank in the cycle after acceptance. `dram_act` follows exactly T_RP cycles later, with no command strobe in between.
- R4: After reset every bank is closed. A request to a closed bank issues `dram_act` in the cycle after acceptance, with no precharge.
- R5: `dram_col` follows `dram_act` by exactly T_RCD cycles, with no command strobe in between.
- R6: For a read, `rsp_valid` is high for BURST consecutive cycles, starting CAS_LAT cycles after the column command. In each of those cycles `rsp_data` equals `dram_rdata`.
- R7: If the requested row is already open in its bank, `dram_col` is issued in the cycle after acceptance, with no precharge or activate.
- R8: During beat i of a burst (i from 0), `dram_addr` holds (column + i) modulo 2^COL_W, so the column wraps within the field. `dram_cs` and `dram_bank` hold the request's rank and bank during every beat.
- R9: A write raises `dram_we` together with `dram_col`. In beat i it raises `dram_wen` and drives `dram_wdata` with bits [i*DATA_W +: DATA_W] of `req_wdata`. Beat 0 is the least significant slice. Outside write beats `dram_wdata` is zero.
- R10: The refresh timer is loaded with REF_INTERVAL-1 at reset and counts down every cycle. Each time it reaches zero it reloads and marks a refresh pending from the next cycle. A pending refresh wins over a waiting request once the block is idle. The refresh runs as follows: a precharge with all chip selects, a `dram_ref` command T_RP cycles later, and a return to idle T_RFC cycles after that. Every bank is then closed, so the next access takes the activate path.
- R11: `req_ready` is high only when the block is idle and no refresh is pending, including the reset state. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is high, all command, chip-select and data outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | RANK_W+BANK_W+ROW_W+COL_W | Flat address {rank, bank, row, column} |
| req_wdata | input | DATA_W*BURST | Write data for the whole burst, beat 0 in the low bits |
| rsp_valid | output | 1 | Read beat valid |
| rsp_data | output | DATA_W | Read beat data |
| dram_cs | output | 2^RANK_W | Chip select per rank, active high |
| dram_pre | output | 1 | Precharge strobe |
| dram_act | output | 1 | Row activate strobe (RAS) |
| dram_col | output | 1 | Column command strobe (CAS) |
| dram_ref | output | 1 | Refresh strobe |
| dram_we | output | 1 | Column command is a write |
| dram_bank | output | BANK_W | Bank of the current command or beat |
| dram_addr | output | max(ROW_W, COL_W) | Row, start column or beat column |
| dram_wen | output | 1 | Write beat strobe |
| dram_wdata | output | DATA_W | Write beat data |
| dram_rdata | input | DATA_W | Read data from the memory |

## Verification
The hardest case to reach is a refresh that becomes pending in the same cycle a waiting request could be accepted. Close behind it is a request that returns to a row it opened before a refresh, which must then take the activate path instead of the page-hit path. The bench keeps requests flowing almost back to back. Most addresses are drawn from four rows across two ranks and four banks, so hits, conflicts and closed banks mix freely. With a short refresh interval, several refreshes land against waiting requests. The reference model tracks the timer and the open rows on its own, so every such collision is checked cycle by cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_COL,
        S_BURST,
        S_RPRE,
        S_REF
    } seq_state_e;

    typedef struct packed {
        logic pre;
        logic act;
        logic col;
        logic rf;
        logic we;
    } dram_cmd_t;

endpackage

// File: rtl/dcs_addr_split.sv
module dcs_addr_split #(
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int ADDR_W = RANK_W + BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [RANK_W-1:0] rank,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    localparam int ROW_LSB  = COL_W;
    localparam int BANK_LSB = COL_W + ROW_W;
    localparam int RANK_LSB = COL_W + ROW_W + BANK_W;

    assign col  = addr[COL_W-1:0];
    assign row  = addr[ROW_LSB +: ROW_W];
    assign bank = addr[BANK_LSB +: BANK_W];
    assign rank = addr[RANK_LSB +: RANK_W];

endmodule

// File: rtl/dcs_row_table.sv
module dcs_row_table #(
    parameter int IDX_W = 3,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [ROW_W-1:0] lk_row,
    output logic             lk_open,
    output logic             lk_hit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_all
);
    localparam int NE = 1 << IDX_W;

    typedef struct packed {
        logic [NE-1:0]            open;
        logic [NE-1:0][ROW_W-1:0] row;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NE; i++) begin
            if (clr_all || (clr_en && clr_idx == IDX_W'(i))) begin
                tbl_d.open[i] = 1'b0;
            end
            if (set_en && set_idx == IDX_W'(i)) begin
                tbl_d.open[i] = 1'b1;
                tbl_d.row[i]  = set_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign lk_open = tbl_q.open[lk_idx];
    assign lk_hit  = tbl_q.open[lk_idx] && (tbl_q.row[lk_idx] == lk_row);

    // R10: a refresh closing every bank never coincides with opening one
    p_set_vs_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_all));

    // R4: the entry opened by an activate reads back as open next cycle
    p_open_after_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> tbl_q.open[$past(set_idx)]);

endmodule

// File: rtl/dcs_ref_timer.sv
module dcs_ref_timer #(
    parameter int INTERVAL = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          due;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.due = tmr_q.due & ~ack;
        if (tmr_q.cnt == '0) begin
            tmr_d.cnt = CW'(INTERVAL - 1);
            tmr_d.due = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= CW'(INTERVAL - 1);
            tmr_q.due <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign due = tmr_q.due;

    // R10: a pending refresh stays pending until it is taken
    p_due_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !ack) |=> due);

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dcs_pkg::*;
#(
    parameter int RANK_W       = 1,
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 8,
    parameter int COL_W        = 6,
    parameter int DATA_W       = 16,
    parameter int BURST        = 4,
    parameter int T_RP         = 3,
    parameter int T_RCD        = 3,
    parameter int CAS_LAT      = 3,
    parameter int T_RFC        = 5,
    parameter int REF_INTERVAL = 160,
    localparam int NR     = 1 << RANK_W,
    localparam int ADDR_W = RANK_W + BANK_W + ROW_W + COL_W,
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int WD_W   = DATA_W * BURST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WD_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [NR-1:0]     dram_cs,
    output logic              dram_pre,
    output logic              dram_act,
    output logic              dram_col,
    output logic              dram_ref,
    output logic              dram_we,
    output logic [BANK_W-1:0] dram_bank,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_wen,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    localparam int IDX_W  = RANK_W + BANK_W;
    localparam int CNT_W  = 8;
    localparam int BEAT_W = (BURST > 2) ? $clog2(BURST) : 1;

    typedef struct packed {
        seq_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [BEAT_W-1:0]   beat;
        logic [RANK_W-1:0]   rank;
        logic [BANK_W-1:0]   bank;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic                wr;
        logic [WD_W-1:0]     wdata;
        logic [NR-1:0]       cs;
        dram_cmd_t           cmd;
        logic [BANK_W-1:0]   obank;
        logic [BUS_W-1:0]    oaddr;
        logic                rv;
        logic                wen;
        logic [DATA_W-1:0]   owd;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [RANK_W-1:0] in_rank;
    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic [IDX_W-1:0]  in_idx;
    logic [IDX_W-1:0]  q_idx;
    logic              lk_open, lk_hit;
    logic              set_en, clr_en, clr_all;
    logic [IDX_W-1:0]  set_idx, clr_idx;
    logic [ROW_W-1:0]  set_row;
    logic              ref_due, ref_ack;
    logic [BEAT_W-1:0] beat_nx;
    logic [COL_W-1:0]  beat_col;
    logic              beat_go;

    dcs_addr_split #(
        .RANK_W (RANK_W),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W)
    ) u_split (
        .addr (req_addr),
        .rank (in_rank),
        .bank (in_bank),
        .row  (in_row),
        .col  (in_col)
    );

    assign in_idx = {in_rank, in_bank};
    assign q_idx  = {seq_q.rank, seq_q.bank};

    dcs_row_table #(
        .IDX_W (IDX_W),
        .ROW_W (ROW_W)
    ) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (in_idx),
        .lk_row  (in_row),
        .lk_open (lk_open),
        .lk_hit  (lk_hit),
        .set_en  (set_en),
        .set_idx (set_idx),
        .set_row (set_row),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .clr_all (clr_all)
    );

    dcs_ref_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .due   (ref_due)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.cs    = '0;
        seq_d.cmd   = '0;
        seq_d.obank = '0;
        seq_d.oaddr = '0;
        seq_d.rv    = 1'b0;
        seq_d.wen   = 1'b0;
        seq_d.owd   = '0;
        set_en      = 1'b0;
        set_idx     = q_idx;
        set_row     = seq_q.row;
        clr_en      = 1'b0;
        clr_idx     = in_idx;
        clr_all     = 1'b0;
        ref_ack     = 1'b0;
        beat_go     = 1'b0;
        beat_nx     = '0;

        case (seq_q.st)
            S_IDLE: begin
                if (ref_due) begin
                    ref_ack       = 1'b1;
                    clr_all       = 1'b1;
                    seq_d.st      = S_RPRE;
                    seq_d.cnt     = CNT_W'(T_RP - 1);
                    seq_d.cs      = '1;
                    seq_d.cmd.pre = 1'b1;
                end else if (req_valid) begin
                    seq_d.rank  = in_rank;
                    seq_d.bank  = in_bank;
                    seq_d.row   = in_row;
                    seq_d.col   = in_col;
                    seq_d.wr    = req_write;
                    seq_d.wdata = req_wdata;
                    seq_d.cs    = NR'(1) << in_rank;
                    seq_d.obank = in_bank;
                    if (lk_hit) begin
                        seq_d.st      = S_COL;
                        seq_d.cnt     = CNT_W'(CAS_LAT - 1);
                        seq_d.cmd.col = 1'b1;
                        seq_d.cmd.we  = req_write;
                        seq_d.oaddr   = BUS_W'(in_col);
                    end else if (lk_open) begin
                        seq_d.st      = S_PRE;
                        seq_d.cnt     = CNT_W'(T_RP - 1);
                        seq_d.cmd.pre = 1'b1;
                        clr_en        = 1'b1;
                    end else begin
                        seq_d.st      = S_ACT;
                        seq_d.cnt     = CNT_W'(T_RCD - 1);
                        seq_d.cmd.act = 1'b1;
                        seq_d.oaddr   = BUS_W'(in_row);
                        set_en        = 1'b1;
                        set_idx       = in_idx;
                        set_row       = in_row;
                    end
                end
            end

            S_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st      = S_ACT;
                    seq_d.cnt     = CNT_W'(T_RCD - 1);
                    seq_d.cs      = NR'(1) << seq_q.rank;
                    seq_d.cmd.act = 1'b1;
                    seq_d.obank   = seq_q.bank;
                    seq_d.oaddr   = BUS_W'(seq_q.row);
                    set_en        = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end

            S_ACT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st      = S_COL;
                    seq_d.cnt     = CNT_W'(CAS_LAT - 1);
                    seq_d.cs      = NR'(1) << seq_q.rank;
                    seq_d.cmd.col = 1'b1;
                    seq_d.cmd.we  = seq_q.wr;
                    seq_d.obank   = seq_q.bank;
                    seq_d.oaddr   = BUS_W'(seq_q.col);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end

            S_COL: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = S_BURST;
                    beat_go  = 1'b1;
                    beat_nx  = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end

            S_BURST: begin
                if (seq_q.beat == BEAT_W'(BURST - 1)) begin
                    seq_d.st = S_IDLE;
                end else begin
                    beat_go = 1'b1;
                    beat_nx = seq_q.beat + BEAT_W'(1);
                end
            end

            S_RPRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st     = S_REF;
                    seq_d.cnt    = CNT_W'(T_RFC - 1);
                    seq_d.cs     = '1;
                    seq_d.cmd.rf = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end

            S_REF: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = S_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end

            default: begin
                seq_d.st = S_IDLE;
            end
        endcase

        beat_col = seq_q.col + COL_W'(beat_nx);
        if (beat_go) begin
            seq_d.beat  = beat_nx;
            seq_d.cs    = NR'(1) << seq_q.rank;
            seq_d.obank = seq_q.bank;
            seq_d.oaddr = BUS_W'(beat_col);
            seq_d.rv    = ~seq_q.wr;
            seq_d.wen   = seq_q.wr;
            seq_d.owd   = seq_q.wr ? seq_q.wdata[int'(beat_nx)*DATA_W +: DATA_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready  = (seq_q.st == S_IDLE) && !ref_due;
    assign rsp_valid  = seq_q.rv;
    assign rsp_data   = dram_rdata;
    assign dram_cs    = seq_q.cs;
    assign dram_pre   = seq_q.cmd.pre;
    assign dram_act   = seq_q.cmd.act;
    assign dram_col   = seq_q.cmd.col;
    assign dram_ref   = seq_q.cmd.rf;
    assign dram_we    = seq_q.cmd.we;
    assign dram_bank  = seq_q.obank;
    assign dram_addr  = seq_q.oaddr;
    assign dram_wen   = seq_q.wen;
    assign dram_wdata = seq_q.owd;

    // Spacing monitor: cycles since the last command strobe and its kind
    logic [7:0] gap_q;
    logic       last_pre_q, last_act_q, last_col_q;
    logic       any_cmd;

    assign any_cmd = dram_pre | dram_act | dram_col | dram_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q      <= 8'd0;
            last_pre_q <= 1'b0;
            last_act_q <= 1'b0;
            last_col_q <= 1'b0;
        end else if (any_cmd) begin
            gap_q      <= 8'd1;
            last_pre_q <= dram_pre;
            last_act_q <= dram_act;
            last_col_q <= dram_col;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    p_pre_to_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_act && last_pre_q) |-> (gap_q == 8'(T_RP)));

    p_act_to_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_col && last_act_q) |-> (gap_q == 8'(T_RCD)));

    p_first_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (last_col_q && gap_q == 8'(CAS_LAT)));

    p_one_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ref && !(dram_pre && dram_cs == '1)) |-> $onehot0(dram_cs));

    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_cs == '0 && !any_cmd && !rsp_valid && !dram_wen));

    p_wen_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_wen && rsp_valid));

endmodule

// File: tb/dram_cmd_seq_tb.sv
module dram_cmd_seq_tb;

    localparam int RANK_W   = 1;
    localparam int BANK_W   = 2;
    localparam int ROW_W    = 8;
    localparam int COL_W    = 6;
    localparam int DATA_W   = 16;
    localparam int BURST    = 4;
    localparam int T_RP     = 3;
    localparam int T_RCD    = 3;
    localparam int CAS_LAT  = 3;
    localparam int T_RFC    = 5;
    localparam int REF_INT  = 160;
    localparam int NR       = 1 << RANK_W;
    localparam int NE       = 1 << (RANK_W + BANK_W);
    localparam int ADDR_W   = RANK_W + BANK_W + ROW_W + COL_W;
    localparam int WD_W     = DATA_W * BURST;
    localparam int TOTAL    = 90;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WD_W-1:0]   req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [NR-1:0]     dram_cs;
    logic              dram_pre, dram_act, dram_col, dram_ref, dram_we;
    logic [BANK_W-1:0] dram_bank;
    logic [ROW_W-1:0]  dram_addr;
    logic              dram_wen;
    logic [DATA_W-1:0] dram_wdata;
    logic [DATA_W-1:0] dram_rdata = '0;

    always #4 clk = ~clk;

    dram_cmd_seq #(
        .RANK_W (RANK_W), .BANK_W (BANK_W), .ROW_W (ROW_W), .COL_W (COL_W),
        .DATA_W (DATA_W), .BURST (BURST), .T_RP (T_RP), .T_RCD (T_RCD),
        .CAS_LAT (CAS_LAT), .T_RFC (T_RFC), .REF_INTERVAL (REF_INT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .dram_cs (dram_cs), .dram_pre (dram_pre), .dram_act (dram_act),
        .dram_col (dram_col), .dram_ref (dram_ref), .dram_we (dram_we),
        .dram_bank (dram_bank), .dram_addr (dram_addr),
        .dram_wen (dram_wen), .dram_wdata (dram_wdata), .dram_rdata (dram_rdata)
    );

    typedef struct {
        logic [NR-1:0]     cs;
        logic              pre, act, col, rf, we;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  addr;
        logic              rv, wen;
        logic [DATA_W-1:0] wd;
        string             tag;
    } rec_t;

    rec_t q[$];
    bit   open_m [NE];
    int   row_m  [NE];
    int   tmr;
    bit   due;
    int   acc_cnt;
    int   n_checks = 0;
    int   n_fail = 0;

    function automatic rec_t blank(string tag);
        rec_t r;
        r.cs = '0; r.pre = 0; r.act = 0; r.col = 0; r.rf = 0; r.we = 0;
        r.bank = '0; r.addr = '0; r.rv = 0; r.wen = 0; r.wd = '0; r.tag = tag;
        return r;
    endfunction

    // Reference model: advances once per rising edge
    always @(posedge clk) begin
        rec_t r;
        bit   was_idle, was_due, wr;
        int   rk, bk, rw, cl, idx;
        if (!rst_n) begin
            q.delete();
            for (int i = 0; i < NE; i++) begin open_m[i] = 0; row_m[i] = 0; end
            tmr = REF_INT - 1;
            due = 0;
            acc_cnt = 0;
        end else begin
            was_idle = (q.size() == 0);
            was_due  = due;
            if (!was_idle) void'(q.pop_front());
            if (was_idle && was_due) begin
                due = 0;
                for (int i = 0; i < NE; i++) open_m[i] = 0;
                r = blank("R10 refresh precharge-all"); r.cs = '1; r.pre = 1; q.push_back(r);
                for (int i = 1; i < T_RP; i++) q.push_back(blank("R10 refresh tRP wait"));
                r = blank("R10 refresh command"); r.cs = '1; r.rf = 1; q.push_back(r);
                for (int i = 1; i < T_RFC; i++) q.push_back(blank("R10 refresh tRFC wait"));
            end else if (was_idle && req_valid) begin
                acc_cnt++;
                cl  = int'(req_addr[COL_W-1:0]);
                rw  = int'(req_addr[COL_W +: ROW_W]);
                bk  = int'(req_addr[COL_W+ROW_W +: BANK_W]);
                rk  = int'(req_addr[COL_W+ROW_W+BANK_W +: RANK_W]);
                wr  = req_write;
                idx = rk * (1 << BANK_W) + bk;
                if (!(open_m[idx] && row_m[idx] == rw)) begin
                    if (open_m[idx]) begin
                        r = blank("R3 precharge on row conflict");
                        r.cs = NR'(1) << rk; r.pre = 1; r.bank = BANK_W'(bk);
                        q.push_back(r);
                        for (int i = 1; i < T_RP; i++) q.push_back(blank("R3 tRP wait"));
                    end
                    r = blank("R1 R4 activate with row");
                    r.cs = NR'(1) << rk; r.act = 1; r.bank = BANK_W'(bk); r.addr = ROW_W'(rw);
                    q.push_back(r);
                    for (int i = 1; i < T_RCD; i++) q.push_back(blank("R5 tRCD wait"));
                    r = blank("R1 R5 column after activate");
                end else begin
                    r = blank("R7 page hit column");
                end
                r.cs = NR'(1) << rk; r.col = 1; r.we = wr; r.bank = BANK_W'(bk); r.addr = ROW_W'(cl);
                q.push_back(r);
                open_m[idx] = 1;
                row_m[idx]  = rw;
                for (int i = 1; i < CAS_LAT; i++) q.push_back(blank("R6 CAS latency wait"));
                for (int b = 0; b < BURST; b++) begin
                    r = blank(wr ? "R8 R9 write beat" : "R6 R8 read beat");
                    r.cs = NR'(1) << rk; r.bank = BANK_W'(bk);
                    r.addr = ROW_W'((cl + b) % (1 << COL_W));
                    r.rv = !wr; r.wen = wr;
                    r.wd = wr ? req_wdata[b*DATA_W +: DATA_W] : '0;
                    q.push_back(r);
                end
            end
            if (tmr == 0) begin due = 1; tmr = REF_INT - 1; end
            else tmr--;
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", what, act, exp, $time);
        end
    endtask

    logic [31:0] lf  = 32'h1ACE_B00C;
    logic [15:0] rlf = 16'hBEEF;

    initial begin
        rec_t e;
        logic [63:0] av, ev;
        int n_done = 0;
        int cyc = 0;
        int tail = 0;
        bit hung = 0;
        logic [RANK_W-1:0] s_rk;
        logic [BANK_W-1:0] s_bk;
        logic [ROW_W-1:0]  s_rw;
        logic [COL_W-1:0]  s_cl;
        logic              s_wr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            rlf = {rlf[14:0], rlf[15] ^ rlf[13] ^ rlf[12] ^ rlf[10]};
            dram_rdata = rlf;
            #1;
            e = (q.size() != 0) ? q[0] : blank("R11 idle outputs");
            check(req_ready == ((q.size() == 0) && !due), "R11 ready", 64'(req_ready),
                  64'((q.size() == 0) && !due));
            av = {dram_cs, dram_pre, dram_act, dram_col, dram_ref, dram_we,
                  dram_bank, dram_addr, rsp_valid, dram_wen, dram_wdata};
            ev = {e.cs, e.pre, e.act, e.col, e.rf, e.we, e.bank, e.addr, e.rv, e.wen, e.wd};
            check(av == ev, e.tag, av, ev);
            if (!(e.rf || (e.pre && e.cs == '1)) && dram_cs != '0)
                check($countones(dram_cs) == 1, "R2 single rank selected", 64'(dram_cs), 64'(e.cs));
            if (e.rv)
                check(rsp_data == dram_rdata, "R6 read data passthrough", 64'(rsp_data), 64'(dram_rdata));

            if (req_valid && acc_cnt > n_done) begin
                n_done++;
                req_valid = 1'b0;
            end
            if (!req_valid && n_done < TOTAL) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                case (n_done)
                    0: begin s_rk = 0; s_bk = 0; s_rw = 8'd5;   s_cl = 6'd8;  s_wr = 0; end
                    1: begin s_rk = 0; s_bk = 0; s_rw = 8'd5;   s_cl = 6'd20; s_wr = 0; end
                    2: begin s_rk = 0; s_bk = 0; s_rw = 8'd5;   s_cl = 6'd62; s_wr = 1; end
                    3: begin s_rk = 0; s_bk = 0; s_rw = 8'd9;   s_cl = 6'd1;  s_wr = 0; end
                    4: begin s_rk = 1; s_bk = 0; s_rw = 8'd9;   s_cl = 6'd3;  s_wr = 0; end
                    5: begin s_rk = 1; s_bk = 3; s_rw = 8'd200; s_cl = 6'd63; s_wr = 1; end
                    default: begin
                        s_rk = lf[0]; s_bk = lf[2:1]; s_rw = {6'd0, lf[4:3]};
                        s_cl = lf[10:5]; s_wr = lf[11];
                    end
                endcase
                if (n_done < 6 || lf[13:12] != 2'b00) begin
                    req_addr  = {s_rk, s_bk, s_rw, s_cl};
                    req_write = s_wr;
                    req_wdata = {lf, ~lf};
                    req_valid = 1'b1;
                end
            end
            if (n_done >= TOTAL && q.size() == 0) tail++;
            if (tail > 8) break;
            if (cyc > 60000) begin hung = 1; break; end
        end
        if (hung) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule